// File: doc/BRIEF.md
# Registered-Acknowledge Bus Memory Slave

This block is a slave on a classic synchronous handshake bus. It holds a small word memory and answers reads and byte-lane writes. A master raises a cycle flag and a strobe together to start a transfer. The write-enable selects the direction, and a per-byte select vector marks which lanes of the data bus are valid.

Both the acknowledge and the read data leave the block from flip-flops. No combinational path runs from the master's request pins back to its acknowledge input. The cost is one cycle of latency on every transfer and a forced idle cycle between transfers. A master that holds its strobe high therefore gets one transfer every two cycles.

The memory is word-addressed. The byte offset of the address is dropped, and any address bits above the word index are ignored, so high addresses wrap onto the memory.

Top module: `regack_mem_slave`

## Requirements
- R1: `ack_o` is high in a cycle only if, at the previous rising edge, `cyc_i` and `stb_i` were both high and `ack_o` was low. Every such edge raises `ack_o`. With either `cyc_i` or `stb_i` low, no acknowledge appears.
- R2: `ack_o` is never high in two consecutive cycles, even when the request stays asserted. It falls in the cycle after the master drops its strobe.
- R3: While `cyc_i` and `stb_i` are held high continuously, exactly one acknowledge occurs per two cycles: N cycles yield N/2 acknowledges.
- R4: In the acknowledge cycle of a read, `dat_o` equals the addressed word as it stood at the accepting edge.
- R5: On a write, only the lanes whose `sel_i` bit is set are updated. Lane b is data bits 8b+7..8b, and `sel_i[b]` enables it. The update happens on the edge that raises the acknowledge, using `dat_i` as sampled on that edge.
- R6: The word index is `adr_i[OFFSET_W +: IDX_W]`, where OFFSET_W = log2(DATA_W/8) and IDX_W = log2(DEPTH). With the defaults this is bits 5..2. The byte-offset bits and the bits above the index have no effect.
- R7: `rst` is synchronous and active high. At the edge where it is sampled high, `ack_o` is cleared to 0 and `dat_o` to all zeros.
- R8: With HOLD_RDATA=1 (the default), `dat_o` changes only on edges that accept a read. Write acknowledges and idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Transfer request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| adr_i | input | ADDR_W | Byte address |
| sel_i | input | DATA_W/8 | Byte-lane valid flags |
| dat_i | input | DATA_W | Write data |
| dat_o | output | DATA_W | Registered read data |
| ack_o | output | 1 | Registered acknowledge |

## Verification
The hardest situation to reach from the ports is a request held across several edges while its fields keep changing. Only the edges that raise the acknowledge may sample those fields, and the edge in between must not capture a second transfer. To get there, the bench holds a write strobe for six cycles and changes the write data every cycle. It then reads the word back, and only the value from the third accepting edge may be present. A held read burst, a strobe dropped during the acknowledge, and a write acknowledge that follows a read show whether acknowledges are spaced correctly and whether read data is held.

// File: rtl/regack_pkg.sv
package regack_pkg;
   localparam int LANE_W = 8;

   typedef enum logic [1:0] {
      REQ_NONE  = 2'd0,
      REQ_READ  = 2'd1,
      REQ_WRITE = 2'd2
   } req_kind_e;
endpackage

// File: rtl/regack_req_decode.sv
module regack_req_decode
   import regack_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int OFFSET_W = 2,
   parameter int IDX_W    = 4
) (
   input  logic              cyc_i,
   input  logic              stb_i,
   input  logic              we_i,
   input  logic              ack_q,
   input  logic [ADDR_W-1:0] adr_i,
   output req_kind_e         kind,
   output logic [IDX_W-1:0]  idx
);
   // A request is taken only while no acknowledge is outstanding, so a
   // held strobe is never answered twice.
   always_comb begin
      kind = REQ_NONE;
      if (cyc_i && stb_i && !ack_q)
         kind = we_i ? REQ_WRITE : REQ_READ;
   end

   // Drop the byte offset; upper bits fall away, so addresses wrap.
   assign idx = adr_i[OFFSET_W +: IDX_W];

   logic unused_adr;
   assign unused_adr = ^adr_i;
endmodule

// File: rtl/regack_ack_reg.sv
module regack_ack_reg
   import regack_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  req_kind_e kind,
   output logic      ack_q
);
   always_ff @(posedge clk) begin
      if (rst)
         ack_q <= 1'b0;
      else
         ack_q <= (kind != REQ_NONE);
   end
endmodule

// File: rtl/regack_lane_mem.sv
module regack_lane_mem
   import regack_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   parameter int IDX_W  = 4
) (
   input  logic                     clk,
   input  logic                     wr_en,
   input  logic [IDX_W-1:0]         idx,
   input  logic [DATA_W/LANE_W-1:0] sel,
   input  logic [DATA_W-1:0]        wdata,
   output logic [DATA_W-1:0]        rdata
);
   localparam int LANES = DATA_W / LANE_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && sel[g])
            cells[idx] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = cells[idx];
   end
endmodule

// File: rtl/regack_rdata_reg.sv
module regack_rdata_reg #(
   parameter int DATA_W     = 32,
   parameter bit HOLD_RDATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] word,
   output logic [DATA_W-1:0] dat_q
);
   if (HOLD_RDATA) begin : g_hold
      always_ff @(posedge clk) begin
         if (rst)
            dat_q <= '0;
         else if (rd_en)
            dat_q <= word;
      end
   end else begin : g_zero
      always_ff @(posedge clk) begin
         if (rst)
            dat_q <= '0;
         else
            dat_q <= rd_en ? word : '0;
      end
   end
endmodule

// File: rtl/regack_mem_slave.sv
module regack_mem_slave
   import regack_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int DEPTH      = 16,
   parameter bit HOLD_RDATA = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                cyc_i,
   input  logic                stb_i,
   input  logic                we_i,
   input  logic [ADDR_W-1:0]   adr_i,
   input  logic [DATA_W/8-1:0] sel_i,
   input  logic [DATA_W-1:0]   dat_i,
   output logic [DATA_W-1:0]   dat_o,
   output logic                ack_o
);
   localparam int SEL_W    = DATA_W / LANE_W;
   localparam int OFFSET_W = $clog2(SEL_W);
   localparam int IDX_W    = $clog2(DEPTH);

   if (DATA_W % LANE_W != 0 || DATA_W < LANE_W) begin : g_bad_width
      $error("DATA_W must be a positive multiple of 8");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end
   if (ADDR_W < OFFSET_W + IDX_W) begin : g_bad_addr
      $error("ADDR_W too narrow for DEPTH words");
   end

   req_kind_e          kind;
   logic [IDX_W-1:0]   idx;
   logic               ack_q;
   logic [DATA_W-1:0]  mem_word;

   regack_req_decode #(
      .ADDR_W   (ADDR_W),
      .OFFSET_W (OFFSET_W),
      .IDX_W    (IDX_W)
   ) u_decode (
      .cyc_i (cyc_i),
      .stb_i (stb_i),
      .we_i  (we_i),
      .ack_q (ack_q),
      .adr_i (adr_i),
      .kind  (kind),
      .idx   (idx)
   );

   regack_ack_reg u_ack (
      .clk   (clk),
      .rst   (rst),
      .kind  (kind),
      .ack_q (ack_q)
   );

   regack_lane_mem #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH),
      .IDX_W  (IDX_W)
   ) u_mem (
      .clk   (clk),
      .wr_en (kind == REQ_WRITE),
      .idx   (idx),
      .sel   (sel_i),
      .wdata (dat_i),
      .rdata (mem_word)
   );

   regack_rdata_reg #(
      .DATA_W     (DATA_W),
      .HOLD_RDATA (HOLD_RDATA)
   ) u_rdata (
      .clk   (clk),
      .rst   (rst),
      .rd_en (kind == REQ_READ),
      .word  (mem_word),
      .dat_q (dat_o)
   );

   assign ack_o = ack_q;
endmodule

// File: rtl/regack_mem_slave_chk.sv
module regack_mem_slave_chk #(
   parameter int DATA_W     = 32,
   parameter bit HOLD_RDATA = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic              cyc_i,
   input logic              stb_i,
   input logic              we_i,
   input logic [DATA_W-1:0] dat_o,
   input logic              ack_o
);
   logic seen_edge = 1'b0;
   always_ff @(posedge clk) seen_edge <= 1'b1;

   assert_ack_needs_req_R1: assert property (@(posedge clk) disable iff (rst)
      (seen_edge && ack_o) |-> $past(cyc_i && stb_i && !ack_o));

   assert_req_gets_ack_R1: assert property (@(posedge clk) disable iff (rst)
      (cyc_i && stb_i && !ack_o) |=> ack_o);

   assert_no_double_ack_R2: assert property (@(posedge clk) disable iff (rst)
      ack_o |=> !ack_o);

   assert_reset_clears_R7: assert property (@(posedge clk)
      (seen_edge && $past(rst)) |-> (!ack_o && dat_o == '0));

   if (HOLD_RDATA) begin : g_hold_chk
      assert_rdata_held_R8: assert property (@(posedge clk) disable iff (rst)
         (seen_edge && !$past(rst) && !$past(cyc_i && stb_i && !ack_o && !we_i))
            |-> $stable(dat_o));
   end
endmodule

bind regack_mem_slave regack_mem_slave_chk #(
   .DATA_W     (DATA_W),
   .HOLD_RDATA (HOLD_RDATA)
) u_chk (
   .clk   (clk),
   .rst   (rst),
   .cyc_i (cyc_i),
   .stb_i (stb_i),
   .we_i  (we_i),
   .dat_o (dat_o),
   .ack_o (ack_o)
);

// File: tb/regack_mem_slave_test.sv
`timescale 1ns/1ps
module regack_mem_slave_test;
   localparam int AW = 8;
   localparam int DW = 32;
   localparam int NW = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cyc = 1'b0, stb = 1'b0, we = 1'b0;
   logic [AW-1:0] adr = '0;
   logic [3:0]    sel = '0;
   logic [DW-1:0] wdat = '0;
   logic [DW-1:0] dat_o;
   logic          ack_o;

   int compared = 0;
   int mismatched = 0;
   bit done = 0;

   always #2 clk = ~clk;

   regack_mem_slave uut (
      .clk(clk), .rst(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we),
      .adr_i(adr), .sel_i(sel), .dat_i(wdat), .dat_o(dat_o), .ack_o(ack_o)
   );

   // Behavioural reference: one transfer per acknowledge, idle forced after.
   logic [DW-1:0] ref_mem [NW];
   logic          m_ack = 1'b0;
   logic [DW-1:0] m_dat = '0;

   always @(posedge clk) begin
      if (rst) begin
         m_ack = 1'b0;
         m_dat = '0;
      end else if (cyc && stb && !m_ack) begin
         int w;
         m_ack = 1'b1;
         w = (int'(adr) / 4) % NW;
         if (we) begin
            for (int b = 0; b < 4; b++)
               if (sel[b]) ref_mem[w][b*8 +: 8] = wdat[b*8 +: 8];
         end else begin
            m_dat = ref_mem[w];
         end
      end else begin
         m_ack = 1'b0;
      end
   end

   task automatic chk(input string tag, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // Per-cycle comparison against the reference (R1, R2, R4).
   logic prev_ack = 1'b0;
   always @(negedge clk) begin
      if (!rst) begin
         chk("R1 ack vs model", {31'd0, ack_o}, {31'd0, m_ack});
         chk("R4 dat_o vs model", dat_o, m_dat);
         if (ack_o && prev_ack)
            chk("R2 consecutive ack", 32'd1, 32'd0);
      end
      prev_ack = ack_o;
   end

   task automatic idle();
      cyc = 0; stb = 0; we = 0;
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [3:0] s,
                            input logic [DW-1:0] d);
      @(negedge clk);
      cyc = 1; stb = 1; we = 1; adr = a; sel = s; wdat = d;
      @(negedge clk);
      chk("R1 write ack", {31'd0, ack_o}, 32'd1);
      idle();
   endtask

   task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      cyc = 1; stb = 1; we = 0; adr = a; sel = 4'hF;
      @(negedge clk);
      chk("R1 read ack", {31'd0, ack_o}, 32'd1);
      d = dat_o;
      idle();
   endtask

   initial begin
      logic [DW-1:0] rd;
      int acks;
      repeat (3) @(negedge clk);
      chk("R7 reset ack", {31'd0, ack_o}, 32'd0);
      chk("R7 reset dat", dat_o, 32'd0);
      rst = 0;

      for (int w = 0; w < NW; w++)
         bus_write(AW'(w * 4), 4'hF, 32'hC3000000 ^ (w * 32'h01010101));
      bus_read(8'd28, rd);
      chk("R4 read word 7", rd, 32'hC3000000 ^ (7 * 32'h01010101));

      // R5 byte lanes: lanes 0 and 2 only
      bus_write(8'd8, 4'hF, 32'h11223344);
      bus_write(8'd8, 4'b0101, 32'hAABBCCDD);
      bus_read(8'd8, rd);
      chk("R5 lane merge", rd, 32'h11BB33DD);

      // R6 wrap and byte offset ignored
      bus_read(8'hC8, rd);
      chk("R6 high bits wrap", rd, 32'h11BB33DD);
      bus_read(8'h0B, rd);
      chk("R6 offset ignored", rd, 32'h11BB33DD);
      bus_write(8'h4C, 4'hF, 32'h5A5A0F0F);
      bus_read(8'h0C, rd);
      chk("R6 wrapped write", rd, 32'h5A5A0F0F);

      // R8 write ack leaves read data untouched
      bus_read(8'd8, rd);
      @(negedge clk);
      cyc = 1; stb = 1; we = 1; adr = 8'd20; sel = 4'hF; wdat = 32'hFFFFFFFF;
      @(negedge clk);
      chk("R8 dat_o held on write ack", dat_o, 32'h11BB33DD);
      idle();
      repeat (2) @(negedge clk);
      chk("R8 dat_o held idle", dat_o, 32'h11BB33DD);

      // R1 partial request gives no ack
      cyc = 0; stb = 1;
      repeat (3) begin
         @(negedge clk);
         chk("R1 stb without cyc", {31'd0, ack_o}, 32'd0);
      end
      cyc = 1; stb = 0;
      repeat (3) begin
         @(negedge clk);
         chk("R1 cyc without stb", {31'd0, ack_o}, 32'd0);
      end
      idle();

      // R3 held read strobe: half bandwidth
      @(negedge clk);
      cyc = 1; stb = 1; we = 0; adr = 8'd28;
      acks = 0;
      repeat (20) begin
         @(negedge clk);
         if (ack_o) acks++;
      end
      idle();
      chk("R3 acks in 20 held cycles", acks, 10);

      // R2 strobe dropped in ack cycle
      @(negedge clk);
      @(negedge clk);
      cyc = 1; stb = 1; we = 0; adr = 8'd4;
      @(negedge clk);
      stb = 0;
      @(negedge clk);
      chk("R2 ack falls after strobe drop", {31'd0, ack_o}, 32'd0);
      idle();

      // R5 held write with changing data: only accepting edges sample
      @(negedge clk);
      cyc = 1; stb = 1; we = 1; adr = 8'd36; sel = 4'hF; wdat = 32'h0000D000;
      for (int k = 1; k <= 6; k++) begin
         @(negedge clk);
         wdat = 32'h0000D000 + k;
      end
      idle();
      bus_read(8'd36, rd);
      chk("R5 held write last accept", rd, 32'h0000D004);

      repeat (3) @(negedge clk);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule